// File: doc/BRIEF.md
# SEC-DED Protection for 32-bit Memory Words

This block guards words held in a memory array against bit upsets. On the write side, a Hamming encoder takes the 32-bit word being stored and produces seven check bits that are kept next to it. On the read side, a decoder takes the stored word and its seven check bits. It returns a corrected word, and it reports whether a correctable single error, an uncorrectable error, or any error at all was seen.

Every parity equation is built as a tree of 4-input XOR stages. Both paths can be registered behind one clock stage or left combinational, chosen by a parameter. The data width is a parameter. The number of Hamming check bits is derived from it, and one extra bit holds overall parity.

Top module: `secded_codec`

## Requirements
- R1: Each data bit i takes a Hamming position: the i-th integer, counting from 0, among the positions from 3 upward that are not a power of two (bit 0 → 3, bit 1 → 5, bit 4 → 9, bit 31 → 38). Check bit k (k = 0..5, carried on bus bit k) is the XOR of all data bits whose position has bit k set. For example, data 32'h1 encodes to 7'h43 and data 32'h8000_0000 encodes to 7'h26.
- R2: Check bus bit 6 is the overall parity bit. Across the 32 data bits and all seven check bits, the number of ones is always even.
- R3: A word read back unchanged is returned as-is, and the single, double and any flags are all low.
- R4: When exactly one of the 32 data bits is flipped, the decoder returns the original word and raises the single and any flags, with the double flag low.
- R5: When exactly one of the seven check bits is flipped, the data passes unchanged and the single and any flags are raised, with the double flag low.
- R6: When exactly two of the 39 stored bits are flipped, the read data passes through uncorrected and the double and any flags are raised, with the single flag low.
- R7: A syndrome above the highest used position (38) together with failed overall parity is uncorrectable. The data passes through and the double and any flags are raised. Flipping all seven check bits gives this case.
- R8: The single and double flags are never high together, and the any flag is high exactly when one of them is.
- R9: With OUT_REG = 1, every output changes one clock after its inputs, and a synchronous active-high reset clears all outputs to zero. With OUT_REG = 0, the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | 32 | Word to be stored |
| enc_chk_o | output | 7 | Check bits for enc_data_i; bit 6 is overall parity |
| dec_data_i | input | 32 | Word read back from storage |
| dec_chk_i | input | 7 | Check bits read back from storage |
| dec_data_o | output | 32 | Corrected read word |
| dec_single_o | output | 1 | Correctable single error seen |
| dec_double_o | output | 1 | Uncorrectable error seen |
| dec_any_o | output | 1 | Any error seen |

## Verification
The bench builds two copies side by side at the default width of 32: one with OUT_REG = 1 and one with OUT_REG = 0. Both copies receive the same stimulus. This covers the one-cycle latency and reset clearing of the registered copy, and it also shows that the combinational decode settles within a cycle. At this width the full 39-bit codeword is small enough to flip every single bit position over several words, every one of the 741 bit pairs on one word, and a spread of pairs on others. The bench also reaches the out-of-range syndrome case.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Hamming check bits needed for dw data bits (overall parity not included).
  function automatic int chk_bits(int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Codeword position of data bit idx: the idx-th non-power-of-two from 3 upward.
  function automatic int data_pos(int idx);
    int cnt;
    int found;
    cnt   = 0;
    found = 0;
    for (int p = 3; p < 2 * idx + 16; p++) begin
      if (found == 0 && (p & (p - 1)) != 0) begin
        if (cnt == idx) found = p;
        cnt++;
      end
    end
    return found;
  endfunction

  // Data bits covered by check bit k (widths up to 64).
  function automatic logic [63:0] cover_mask(int dw, int k);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < dw; i++) m[i] = ((data_pos(i) >> k) & 1) != 0;
    return m;
  endfunction

  // Number of 4-input XOR stages needed to reduce n bits to one.
  function automatic int tree_levels(int n);
    int l;
    int w;
    l = 0;
    w = n;
    while (w > 1) begin
      w = (w + 3) / 4;
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/secded_xor4_tree.sv
module secded_xor4_tree
  import secded_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] bits_i,
  output logic         par_o
);
  localparam int LVLS = tree_levels(N);
  localparam int NP   = 4 ** LVLS;          // leaves, padded to a power of four
  localparam int TOT  = (4 * NP - 1) / 3;   // total nodes in the tree

  function automatic int lvl_off(int l);
    int off;
    int w;
    off = 0;
    w   = NP;
    for (int i = 0; i < l; i++) begin
      off += w;
      w   /= 4;
    end
    return off;
  endfunction

  logic [TOT-1:0] node;

  for (genvar g = 0; g < NP; g++) begin : g_leaf
    if (g < N) begin : g_in
      assign node[g] = bits_i[g];
    end else begin : g_pad
      assign node[g] = 1'b0;
    end
  end

  for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
    localparam int SRC = lvl_off(l - 1);
    localparam int DST = lvl_off(l);
    for (genvar g = 0; g < NP / (4 ** l); g++) begin : g_x4
      assign node[DST+g] = ^node[SRC+4*g +: 4];
    end
  end

  assign par_o = node[TOT-1];
endmodule

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         data_i,
  output logic [chk_bits(DATA_W):0] chk_o
);
  localparam int CHK_W = chk_bits(DATA_W);

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [63:0] MASK = cover_mask(DATA_W, k);
    secded_xor4_tree #(.N(DATA_W)) u_tree (
      .bits_i (data_i & MASK[DATA_W-1:0]),
      .par_o  (chk_o[k])
    );
  end

  // Overall parity over the data and Hamming bits.
  secded_xor4_tree #(.N(DATA_W + CHK_W)) u_all (
    .bits_i ({chk_o[CHK_W-1:0], data_i}),
    .par_o  (chk_o[CHK_W])
  );
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         data_i,
  input  logic [chk_bits(DATA_W):0] chk_i,
  output logic [DATA_W-1:0]         data_o,
  output logic                      single_o,
  output logic                      double_o,
  output logic                      any_o
);
  localparam int CHK_W   = chk_bits(DATA_W);
  localparam int MAX_POS = data_pos(DATA_W - 1);

  logic [CHK_W-1:0] syn;
  logic             ovr_fail;
  logic             syn_hit;
  logic             in_range;

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    localparam logic [63:0] MASK = cover_mask(DATA_W, k);
    secded_xor4_tree #(.N(DATA_W + 1)) u_tree (
      .bits_i ({chk_i[k], data_i & MASK[DATA_W-1:0]}),
      .par_o  (syn[k])
    );
  end

  secded_xor4_tree #(.N(DATA_W + CHK_W + 1)) u_all (
    .bits_i ({chk_i, data_i}),
    .par_o  (ovr_fail)
  );

  assign syn_hit  = (syn != '0);
  assign in_range = (32'(syn) <= 32'(MAX_POS));
  assign single_o = ovr_fail && in_range;
  assign double_o = (syn_hit && !ovr_fail) || (ovr_fail && !in_range);
  assign any_o    = ovr_fail || syn_hit;

  // Flip the one data bit whose position the syndrome names.
  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam logic [CHK_W-1:0] POS = CHK_W'(data_pos(i));
    assign data_o[i] = data_i[i] ^ (single_o && (syn == POS));
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DATA_W-1:0]         enc_data_i,
  output logic [chk_bits(DATA_W):0] enc_chk_o,
  input  logic [DATA_W-1:0]         dec_data_i,
  input  logic [chk_bits(DATA_W):0] dec_chk_i,
  output logic [DATA_W-1:0]         dec_data_o,
  output logic                      dec_single_o,
  output logic                      dec_double_o,
  output logic                      dec_any_o
);
  localparam int CW = chk_bits(DATA_W) + 1;

  logic [CW-1:0]     enc_chk_c;
  logic [DATA_W-1:0] dec_data_c;
  logic              dec_single_c;
  logic              dec_double_c;
  logic              dec_any_c;

  secded_encoder #(.DATA_W(DATA_W)) u_enc (
    .data_i (enc_data_i),
    .chk_o  (enc_chk_c)
  );

  secded_decoder #(.DATA_W(DATA_W)) u_dec (
    .data_i   (dec_data_i),
    .chk_i    (dec_chk_i),
    .data_o   (dec_data_c),
    .single_o (dec_single_c),
    .double_o (dec_double_c),
    .any_o    (dec_any_c)
  );

  // Flag consistency holds in either build.
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(dec_single_o && dec_double_o));
  assert_any_matches_R8: assert property (@(posedge clk) disable iff (rst)
    dec_any_o == (dec_single_o || dec_double_o));

  if (OUT_REG) begin : g_reg
    logic primed;

    always_ff @(posedge clk) begin
      if (rst) begin
        enc_chk_o    <= '0;
        dec_data_o   <= '0;
        dec_single_o <= 1'b0;
        dec_double_o <= 1'b0;
        dec_any_o    <= 1'b0;
        primed       <= 1'b0;
      end else begin
        enc_chk_o    <= enc_chk_c;
        dec_data_o   <= dec_data_c;
        dec_single_o <= dec_single_c;
        dec_double_o <= dec_double_c;
        dec_any_o    <= dec_any_c;
        primed       <= 1'b1;
      end
    end

    assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (enc_chk_o == '0 && dec_data_o == '0 && !dec_any_o));
    assert_even_parity_R2: assert property (@(posedge clk) disable iff (rst)
      primed |-> (^{enc_chk_o, $past(enc_data_i)}) == 1'b0);
    assert_clean_pass_R3: assert property (@(posedge clk) disable iff (rst)
      (primed && !dec_any_o) |-> dec_data_o == $past(dec_data_i));
    assert_double_pass_R6: assert property (@(posedge clk) disable iff (rst)
      (primed && dec_double_o) |-> dec_data_o == $past(dec_data_i));
  end else begin : g_comb
    assign enc_chk_o    = enc_chk_c;
    assign dec_data_o   = dec_data_c;
    assign dec_single_o = dec_single_c;
    assign dec_double_o = dec_double_c;
    assign dec_any_o    = dec_any_c;

    assert_even_parity_R2: assert property (@(posedge clk) disable iff (rst)
      (^{enc_chk_o, enc_data_i}) == 1'b0);
    assert_clean_pass_R3: assert property (@(posedge clk) disable iff (rst)
      !dec_any_o |-> dec_data_o == dec_data_i);
    assert_double_pass_R6: assert property (@(posedge clk) disable iff (rst)
      dec_double_o |-> dec_data_o == dec_data_i);
  end
endmodule

// File: tb/secded_codec_tb.sv
module secded_codec_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] enc_data = '0;
  logic [31:0] dec_data = '0;
  logic [6:0]  dec_chk  = '0;

  logic [6:0]  r_chk,  c_chk;
  logic [31:0] r_data, c_data;
  logic        r_s, r_d, r_a, c_s, c_d, c_a;

  int n_cmp = 0;
  int n_bad = 0;

  secded_codec #(.DATA_W(32), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .enc_data_i(enc_data), .enc_chk_o(r_chk),
    .dec_data_i(dec_data), .dec_chk_i(dec_chk), .dec_data_o(r_data),
    .dec_single_o(r_s), .dec_double_o(r_d), .dec_any_o(r_a));

  secded_codec #(.DATA_W(32), .OUT_REG(1'b0)) u_dut_comb (
    .clk(clk), .rst(rst), .enc_data_i(enc_data), .enc_chk_o(c_chk),
    .dec_data_i(dec_data), .dec_chk_i(dec_chk), .dec_data_o(c_data),
    .dec_single_o(c_s), .dec_double_o(c_d), .dec_any_o(c_a));

  // Reference model built from R1/R2.
  function automatic int ref_pos(int i);
    int cnt = 0;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == i) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  function automatic logic [6:0] ref_chk(logic [31:0] d);
    logic [6:0] c = '0;
    for (int i = 0; i < 32; i++)
      for (int k = 0; k < 6; k++)
        if (((ref_pos(i) >> k) & 1) != 0) c[k] ^= d[i];
    c[6] = ^{c[5:0], d};
    return c;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive a read word; check the combinational copy now and the registered copy after one edge.
  task automatic apply_dec(string tag, logic [31:0] d, logic [6:0] c,
                           logic [31:0] ed, logic es, logic edb);
    @(negedge clk);
    dec_data = d;
    dec_chk  = c;
    #1;
    check({tag, " comb"}, {29'd0, c_data, c_a, c_d, c_s}, {29'd0, ed, es | edb, edb, es});
    @(negedge clk);
    check({tag, " reg"}, {29'd0, r_data, r_a, r_d, r_s}, {29'd0, ed, es | edb, edb, es});
  endtask

  task automatic t_reset();
    enc_data = 32'hFFFF_FFFF;
    dec_data = 32'h1234_5678;
    dec_chk  = 7'h55;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset clears", {r_chk, r_data, r_s, r_d, r_a}, '0);
    rst = 1'b0;
  endtask

  task automatic t_encode();
    logic [31:0] pats [6] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A,
                              32'h1234_5678, 32'h8000_0001, 32'h0F0F_00FF};
    @(negedge clk); enc_data = 32'h1; #1;
    check("R1 bit0 literal", {57'd0, c_chk}, {57'd0, 7'h43});
    @(negedge clk); enc_data = 32'h8000_0000; #1;
    check("R1 bit31 literal", {57'd0, c_chk}, {57'd0, 7'h26});
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); enc_data = pats[i]; #1;
      check("R1 R2 encode comb", {57'd0, c_chk}, {57'd0, ref_chk(pats[i])});
      @(negedge clk);
      check("R1 R2 encode reg", {57'd0, r_chk}, {57'd0, ref_chk(pats[i])});
      check("R2 even ones", {63'd0, ^{r_chk, pats[i]}}, '0);
    end
  endtask

  task automatic t_clean();
    logic [31:0] pats [4] = '{32'h0, 32'hFFFF_FFFF, 32'hC3C3_3C3C, 32'h7E57_0001};
    for (int i = 0; i < 4; i++)
      apply_dec("R3 clean", pats[i], ref_chk(pats[i]), pats[i], 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    logic [31:0] a = 32'h0000_FFFF;
    logic [31:0] b = 32'h5555_AAAA;
    apply_dec("R9 lead-in", a, ref_chk(a), a, 1'b0, 1'b0);
    dec_data = b ^ 32'h0000_0100;
    dec_chk  = ref_chk(b);
    #1;
    check("R9 reg holds old", {29'd0, r_data, r_a, r_d, r_s}, {29'd0, a, 3'b000});
    check("R9 comb immediate", {29'd0, c_data, c_a, c_d, c_s}, {29'd0, b, 3'b101});
    @(negedge clk);
    check("R9 reg after edge", {29'd0, r_data, r_a, r_d, r_s}, {29'd0, b, 3'b101});
  endtask

  task automatic t_single();
    logic [31:0] pats [4] = '{32'h0, 32'hFFFF_FFFF, 32'h9E37_79B9, 32'h0000_0001};
    for (int w = 0; w < 4; w++) begin
      for (int j = 0; j < 39; j++) begin
        logic [38:0] cw = {ref_chk(pats[w]), pats[w]};
        cw[j] = ~cw[j];
        if (j < 32) apply_dec("R4 single data", cw[31:0], cw[38:32], pats[w], 1'b1, 1'b0);
        else        apply_dec("R5 single check", cw[31:0], cw[38:32], pats[w], 1'b1, 1'b0);
      end
    end
  endtask

  task automatic t_double();
    logic [31:0] w0 = 32'h3C96_E10F;
    for (int a = 0; a < 39; a++) begin
      for (int b = a + 1; b < 39; b++) begin
        logic [38:0] cw = {ref_chk(w0), w0};
        cw[a] = ~cw[a];
        cw[b] = ~cw[b];
        apply_dec("R6 R8 double all pairs", cw[31:0], cw[38:32], cw[31:0], 1'b0, 1'b1);
      end
    end
    for (int a = 0; a < 39; a++) begin
      logic [31:0] w1 = 32'hFFFF_FFFF ^ (32'h1 << (a % 32));
      logic [38:0] cw = {ref_chk(w1), w1};
      int b = (a * 7 + 5) % 39;
      if (b != a) begin
        cw[a] = ~cw[a];
        cw[b] = ~cw[b];
        apply_dec("R6 double sampled", cw[31:0], cw[38:32], cw[31:0], 1'b0, 1'b1);
      end
    end
  endtask

  task automatic t_beyond();
    logic [31:0] w = 32'h0BAD_F00D;
    apply_dec("R7 syndrome out of range", w, ref_chk(w) ^ 7'h7F, w, 1'b0, 1'b1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    t_reset();
    t_encode();
    t_clean();
    t_latency();
    t_single();
    t_double();
    t_beyond();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=timeout expected=done");
    summary();
    $finish;
  end
endmodule